// File: doc/BRIEF.md
# I2C Master Control Register Unit

This unit holds the software-visible control state of an I2C master. It provides an enable bit, a transmit-empty interrupt enable, and two request bits: one asks for a STOP condition and one asks for a Not-Acknowledge. It also holds the transmit data register together with its empty flag. A host writes and reads these through a byte-wide port. The byte engine sees the requests as levels. It reports its progress back as single-cycle events: stop sent, NAK sent, byte done and data taken. A further input is a level that is high while a slave-mode transaction is in progress.

The request bits are sticky. Software can set them but cannot clear them. Only the engine's completion events, a slave transaction or loss of the enable clear them. A flush command empties the data register and forces the empty flag in one step, so a byte that was written but will never go out can be thrown away.

Register map (ADDR_W bits): 0 = control, 1 = transmit data, 2 = status, 3 = reads zero. Control bits: 0 enable, 1 STOP request, 2 NAK request, 3 flush (write-only), 4 interrupt enable. Status bit 0 = data register empty.

Top module: `i2cm_ctl_unit`

## Requirements
- R1: After reset, control reads 0x00, data reads 0x00, status reads 0x01 (empty), and irq_o, stop_req_o, nak_req_o, flush_o and tdre_set_o are all 0.
- R2: While enable (control bit 0) is already 1, writing control with bit 1 set makes stop_req_o 1 after that write. Writing control with bit 2 set makes nak_req_o 1 after that write. Each bit then reads back as 1.
- R3: Writing control with bit 1 or bit 2 equal to 0 leaves a set STOP or NAK request at 1.
- R4: A stop_sent_i pulse clears the STOP request and leaves NAK unchanged. A nak_sent_i pulse clears the NAK request and leaves STOP unchanged.
- R5: While enable is 0, or when a control write clears enable, both requests are cleared. A request written while enable is still 0 is not accepted, even when the same write sets enable.
- R6: slave_active_i high clears the STOP request and leaves NAK unchanged.
- R7: When a hardware clear of a request and a software set of the same request fall in the same cycle, the request ends up 0.
- R8: Writing control with bit 3 set makes the data register 0 and the empty flag 1. flush_o and tdre_set_o are each high for exactly the one cycle after that write. Control bit 3 always reads 0.
- R9: A write to the data address stores the byte and clears the empty flag. A data_taken_i pulse sets the empty flag, keeps the byte, and raises tdre_set_o for the following cycle.
- R10: irq_o equals interrupt enable (control bit 4) AND the empty flag.
- R11: stop_issue_o is high exactly in the cycles where the STOP request is 1 and byte_done_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Read data for host_addr_i (combinational) |
| stop_sent_i | input | 1 | Engine finished a STOP condition |
| nak_sent_i | input | 1 | Engine finished sending a NAK |
| byte_done_i | input | 1 | Engine finished the current byte |
| slave_active_i | input | 1 | A slave-mode transaction is in progress |
| data_taken_i | input | 1 | Engine consumed the data register |
| stop_req_o | output | 1 | STOP request level |
| nak_req_o | output | 1 | NAK request level |
| stop_issue_o | output | 1 | Issue STOP now: request pending at a byte boundary |
| data_o | output | DATA_W | Transmit data register contents |
| data_empty_o | output | 1 | Data register empty flag |
| flush_o | output | 1 | One-cycle flush strobe |
| tdre_set_o | output | 1 | One-cycle strobe: empty flag was set |
| irq_o | output | 1 | Transmit-empty interrupt |

## Verification
The bench targets the cases where software and hardware disagree about a request bit.

- **Writes of 0 to a set request.** A design that treated the request as an ordinary read-write bit would lose the request.
- **Same-cycle set and clear.** A design giving the software set priority would leave the request stuck at 1 after the engine has already sent the condition.
- **Setting a request in the same write that sets enable.** A design that looked at the new enable value instead of the held one would accept a request it should have refused.
- **Flush.** The bench checks that the data register reads 0, that the flush bit itself reads 0, and that both strobes last exactly one cycle. A design that held the flush as a stored bit would repeat the flush.
- **Data taken.** The bench checks that the byte is kept while the empty flag rises and the interrupt follows it.

// File: rtl/i2cm_ctl_pkg.sv
package i2cm_ctl_pkg;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_STOP  = 1;
  localparam int unsigned BIT_NAK   = 2;
  localparam int unsigned BIT_FLUSH = 3;
  localparam int unsigned BIT_TXIE  = 4;
  localparam int unsigned CTRL_BITS = 5;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_DATA = 1;
  localparam int unsigned ADR_STAT = 2;

  localparam int unsigned N_REQ   = 2;
  localparam int unsigned REQ_STOP = 0;
  localparam int unsigned REQ_NAK  = 1;
endpackage

// File: rtl/i2cm_sticky_req.sv
module i2cm_sticky_req (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (clr_i)      q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o && !clr_i |=> q_o);
  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  // R2
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !clr_i |=> q_o);
endmodule

// File: rtl/i2cm_data_reg.sv
module i2cm_data_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flush_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              flush_o,
  output logic              tdre_set_o
);
  logic [DATA_W-1:0] data_d, data_q;
  logic              empty_d, empty_q;
  logic              flush_q, tset_d, tset_q;
  logic              data_en;

  always_comb begin
    data_d  = data_q;
    empty_d = empty_q;
    tset_d  = 1'b0;
    data_en = 1'b0;
    if (flush_i) begin
      data_d  = '0;
      empty_d = 1'b1;
      tset_d  = 1'b1;
      data_en = 1'b1;
    end else if (wr_i) begin
      data_d  = wdata_i;
      empty_d = 1'b0;
      data_en = 1'b1;
    end else if (take_i) begin
      empty_d = 1'b1;
      tset_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
      flush_q <= 1'b0;
      tset_q  <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      empty_q <= empty_d;
      flush_q <= flush_i;
      tset_q  <= tset_d;
    end
  end

  assign data_o     = data_q;
  assign empty_o    = empty_q;
  assign flush_o    = flush_q;
  assign tdre_set_o = tset_q;

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (empty_o && data_o == '0 && flush_o && tdre_set_o));
  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && !flush_i |=> (!empty_o && data_o == $past(wdata_i)));
  // R9
  take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !wr_i && !flush_i |=> (empty_o && $stable(data_o) && tdre_set_o));
endmodule

// File: rtl/i2cm_ctl_unit.sv
module i2cm_ctl_unit
  import i2cm_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              stop_sent_i,
  input  logic              nak_sent_i,
  input  logic              byte_done_i,
  input  logic              slave_active_i,
  input  logic              data_taken_i,
  output logic              stop_req_o,
  output logic              nak_req_o,
  output logic              stop_issue_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_empty_o,
  output logic              flush_o,
  output logic              tdre_set_o,
  output logic              irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  logic wr_ctrl, wr_data;
  assign wr_ctrl = host_wr_i && (host_addr_i == ADDR_W'(ADR_CTRL));
  assign wr_data = host_wr_i && (host_addr_i == ADDR_W'(ADR_DATA));

  logic en_d, en_q, txie_d, txie_q, ctl_en;
  assign ctl_en = wr_ctrl;

  always_comb begin
    en_d   = host_wdata_i[BIT_EN];
    txie_d = host_wdata_i[BIT_TXIE];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      en_q   <= 1'b0;
      txie_q <= 1'b0;
    end else if (ctl_en) begin
      en_q   <= en_d;
      txie_q <= txie_d;
    end
  end

  logic disable_now;
  assign disable_now = !en_q || (wr_ctrl && !host_wdata_i[BIT_EN]);

  logic [N_REQ-1:0] req_set, req_clr, req_q;
  always_comb begin
    req_set[REQ_STOP] = wr_ctrl && host_wdata_i[BIT_STOP];
    req_set[REQ_NAK]  = wr_ctrl && host_wdata_i[BIT_NAK];
    req_clr[REQ_STOP] = disable_now || stop_sent_i || slave_active_i;
    req_clr[REQ_NAK]  = disable_now || nak_sent_i;
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    i2cm_sticky_req u_req (
      .clk   (clk),
      .rst_n (rst_l),
      .set_i (req_set[g]),
      .clr_i (req_clr[g]),
      .q_o   (req_q[g])
    );
  end

  logic flush_cmd;
  assign flush_cmd = wr_ctrl && host_wdata_i[BIT_FLUSH];

  i2cm_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_l),
    .wr_i       (wr_data),
    .wdata_i    (host_wdata_i),
    .flush_i    (flush_cmd),
    .take_i     (data_taken_i),
    .data_o     (data_o),
    .empty_o    (data_empty_o),
    .flush_o    (flush_o),
    .tdre_set_o (tdre_set_o)
  );

  assign stop_req_o   = req_q[REQ_STOP];
  assign nak_req_o    = req_q[REQ_NAK];
  assign stop_issue_o = req_q[REQ_STOP] && byte_done_i;
  assign irq_o        = txie_q && data_empty_o;

  logic [DATA_W-1:0] ctrl_view;
  always_comb begin
    ctrl_view            = '0;
    ctrl_view[BIT_EN]    = en_q;
    ctrl_view[BIT_STOP]  = req_q[REQ_STOP];
    ctrl_view[BIT_NAK]   = req_q[REQ_NAK];
    ctrl_view[BIT_TXIE]  = txie_q;
    host_rdata_o = '0;
    if (host_addr_i == ADDR_W'(ADR_CTRL))      host_rdata_o = ctrl_view;
    else if (host_addr_i == ADDR_W'(ADR_DATA)) host_rdata_o = data_o;
    else if (host_addr_i == ADDR_W'(ADR_STAT)) host_rdata_o[0] = data_empty_o;
  end

  // R5
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_l)
    !en_q |=> (!stop_req_o && !nak_req_o));
  // R6
  slave_clr_chk: assert property (@(posedge clk) disable iff (!rst_l)
    slave_active_i |=> !stop_req_o);
  // R8
  flush_rd_chk: assert property (@(posedge clk) disable iff (!rst_l)
    flush_o |-> (data_empty_o && data_o == '0));
  // R10
  irq_chk: assert property (@(posedge clk) disable iff (!rst_l)
    irq_o |-> data_empty_o);
endmodule

// File: tb/sim_i2cm_ctl_unit.sv
module sim_i2cm_ctl_unit;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic [DW-1:0] host_rdata;
  logic          stop_sent, nak_sent, byte_done, slave_active, data_taken;
  logic          stop_req, nak_req, stop_issue, data_empty, flush_s, tdre_set, irq;
  logic [DW-1:0] data_v;

  always #10 clk = ~clk;

  i2cm_ctl_unit #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .stop_sent_i(stop_sent), .nak_sent_i(nak_sent), .byte_done_i(byte_done),
    .slave_active_i(slave_active), .data_taken_i(data_taken),
    .stop_req_o(stop_req), .nak_req_o(nak_req), .stop_issue_o(stop_issue),
    .data_o(data_v), .data_empty_o(data_empty), .flush_o(flush_s),
    .tdre_set_o(tdre_set), .irq_o(irq)
  );

  typedef struct {
    int            sel;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t exp_q[$];
  event  smp;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  // Monitor: pops expected items and compares them with the selected output
  initial begin
    forever begin
      @(smp);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [DW-1:0] act;
        it = exp_q.pop_front();
        case (it.sel)
          0: act = host_rdata;
          1: act = DW'(stop_req);
          2: act = DW'(nak_req);
          3: act = DW'(irq);
          4: act = DW'(flush_s);
          5: act = DW'(tdre_set);
          6: act = DW'(stop_issue);
          default: act = data_v;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_out(input int sel, input logic [DW-1:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    -> smp;
    #1;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    host_addr = a;
    #1;
    expect_out(0, exp, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    stop_sent = 0; nak_sent = 0; byte_done = 0; slave_active = 0; data_taken = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1 reset state
    rd_chk(2'd0, 8'h00, "R1 ctrl");
    rd_chk(2'd1, 8'h00, "R1 data");
    rd_chk(2'd2, 8'h01, "R1 status");
    rd_chk(2'd3, 8'h00, "R1 unused");
    expect_out(3, 0, "R1 irq");
    expect_out(1, 0, "R1 stop_req");
    expect_out(2, 0, "R1 nak_req");
    expect_out(4, 0, "R1 flush");
    expect_out(5, 0, "R1 tdre_set");

    // R5 request refused in the write that enables
    wr(2'd0, 8'h03);
    rd_chk(2'd0, 8'h01, "R5 set with enable");

    // R2 set stop
    wr(2'd0, 8'h03);
    rd_chk(2'd0, 8'h03, "R2 stop set");
    expect_out(1, 1, "R2 stop_req");

    // R3 write 0 ignored
    wr(2'd0, 8'h01);
    rd_chk(2'd0, 8'h03, "R3 stop sticky");

    // R11 stop issue at byte boundary
    expect_out(6, 0, "R11 no byte_done");
    byte_done = 1'b1; #1;
    expect_out(6, 1, "R11 issue");
    idle_cycle(); byte_done = 1'b0;

    // R4 stop_sent clears stop
    stop_sent = 1'b1; idle_cycle(); stop_sent = 1'b0;
    rd_chk(2'd0, 8'h01, "R4 stop cleared");
    byte_done = 1'b1; #1;
    expect_out(6, 0, "R11 no request");
    byte_done = 1'b0;

    // R2/R3/R4 NAK
    wr(2'd0, 8'h05);
    expect_out(2, 1, "R2 nak_req");
    wr(2'd0, 8'h01);
    rd_chk(2'd0, 8'h05, "R3 nak sticky");
    stop_sent = 1'b1; idle_cycle(); stop_sent = 1'b0;
    rd_chk(2'd0, 8'h05, "R4 stop_sent keeps nak");
    nak_sent = 1'b1; idle_cycle(); nak_sent = 1'b0;
    rd_chk(2'd0, 8'h01, "R4 nak cleared");

    // R4 nak_sent keeps stop
    wr(2'd0, 8'h07);
    nak_sent = 1'b1; idle_cycle(); nak_sent = 1'b0;
    rd_chk(2'd0, 8'h03, "R4 nak_sent keeps stop");

    // R6 slave activity clears stop only
    wr(2'd0, 8'h07);
    slave_active = 1'b1; idle_cycle(); slave_active = 1'b0;
    rd_chk(2'd0, 8'h05, "R6 slave clears stop");

    // R5 disable clears both
    wr(2'd0, 8'h07);
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h00, "R5 disable clears");
    expect_out(2, 0, "R5 nak_req low");

    // R7 same-cycle conflicts
    wr(2'd0, 8'h01);
    @(negedge clk); #1;
    host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h03; stop_sent = 1'b1;
    @(negedge clk); #1;
    host_wr = 1'b0; stop_sent = 1'b0;
    rd_chk(2'd0, 8'h01, "R7 stop clear wins");
    @(negedge clk); #1;
    host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h05; nak_sent = 1'b1;
    @(negedge clk); #1;
    host_wr = 1'b0; nak_sent = 1'b0;
    rd_chk(2'd0, 8'h01, "R7 nak clear wins");

    // R9/R10 data path and interrupt
    wr(2'd1, 8'hA5);
    rd_chk(2'd1, 8'hA5, "R9 data stored");
    rd_chk(2'd2, 8'h00, "R9 not empty");
    wr(2'd0, 8'h11);
    expect_out(3, 0, "R10 irq off when full");
    data_taken = 1'b1; idle_cycle(); data_taken = 1'b0;
    expect_out(5, 1, "R9 tdre_set pulse");
    rd_chk(2'd2, 8'h01, "R9 empty after take");
    rd_chk(2'd1, 8'hA5, "R9 byte kept");
    expect_out(3, 1, "R10 irq on");
    idle_cycle();
    expect_out(5, 0, "R9 tdre_set one cycle");
    wr(2'd0, 8'h01);
    expect_out(3, 0, "R10 irq disabled");

    // R8 flush
    wr(2'd1, 8'h3C);
    wr(2'd0, 8'h19);
    expect_out(4, 1, "R8 flush strobe");
    expect_out(5, 1, "R8 tdre_set strobe");
    rd_chk(2'd1, 8'h00, "R8 data cleared");
    rd_chk(2'd2, 8'h01, "R8 empty set");
    rd_chk(2'd0, 8'h11, "R8 flush reads 0");
    expect_out(7, 8'h00, "R8 data_o cleared");
    idle_cycle();
    expect_out(4, 0, "R8 flush one cycle");
    expect_out(5, 0, "R8 tdre_set one cycle");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule